// File: doc/BRIEF.md
# Serial DAC Input Interface Controller

This block is the digital front end of a single-channel 16-bit voltage-output converter. A host writes 24-bit frames over a three-wire serial port: a serial clock, a data line and an active-low frame select. The block oversamples all three wires with its own system clock, which must run at least four times the serial clock. It collects the bits into a shift register and, once a frame is complete, loads a new converter code and a power-down mode together.

Between frames the block ignores the serial clock. A frame cut short by an early rise of frame select is dropped. Clocks that arrive after the 24th bit are dropped too, until frame select goes high and falls again. A strap input picks the code loaded at reset, either midscale or zero. That code holds until the first complete frame. The outputs are the code, the two-bit power-down mode, and a one-hot select that tells the analog output stage which load to apply.

Top module: `serdac_frontend`

## Requirements
- R1: While `rstN` is low, `dacCode` takes 0x8000 if `resetToMid` is 1 and 0x0000 if it is 0. `pdMode` takes 00 and `loadSel` takes 000. These values hold until the first complete frame.
- R2: A frame starts when `frameSelN` falls. `serData` is sampled on each falling edge of `serClk`, most significant bit (bit 23) first. Bits [15:0] carry the code in straight binary and bits [17:16] carry the power-down mode. Bits [23:18] have no effect.
- R3: A frame takes effect only on its 24th falling edge of `serClk`. The outputs change within four system clocks of that edge and never earlier.
- R4: If `frameSelN` rises before the 24th falling edge, the frame is discarded and `dacCode` and `pdMode` keep their values.
- R5: Falling edges of `serClk` after the 24th edge of a frame, while `frameSelN` stays low, have no effect. Only a new low period of `frameSelN` starts another frame.
- R6: Falling edges of `serClk` while `frameSelN` is high have no effect.
- R7: `loadSel` is one-hot or zero, decoded from `pdMode`. Mode 00 (normal) gives 000. Mode 01 sets bit 0 (1 kOhm to ground). Mode 10 sets bit 1 (100 kOhm to ground). Mode 11 sets bit 2 (three-state output).
- R8: A frame that selects a power-down mode still updates `dacCode`. A frame that selects mode 00 loads the new code and leaves power-down in the same system clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Synchronous active-low reset |
| resetToMid | input | 1 | Reset code strap: 1 gives midscale, 0 gives zero |
| serClk | input | 1 | Serial clock from the host, asynchronous to clk |
| serData | input | 1 | Serial data, sampled on falling edges of serClk |
| frameSelN | input | 1 | Active-low frame select |
| dacCode | output | 16 | Code driven to the converter |
| pdMode | output | 2 | Power-down mode, 00 for normal operation |
| loadSel | output | 3 | One-hot output load select for power-down |

## Verification
The hardest conditions to reach from the ports are those where serial clock edges arrive but must not count: edges after a frame is already complete, and edges cut off by an early rise of frame select. Directed cases set these up. One sends extra clocked bits after bit 24 whose data differs from the frame. One stops one bit short. One pulses the clock with frame select high. Another samples the outputs between the 23rd and 24th edge. A seeded random loop then mixes full frames, truncated frames and frames with extra clocks. Expected values are tracked by a model that changes only on frames of exactly 24 bits.

// File: rtl/serdac_pkg.sv
package serdac_pkg;

  localparam int MODE_W    = 2;
  localparam int NUM_MODES = 1 << MODE_W;

  localparam logic [MODE_W-1:0] MODE_NORMAL = 2'b00;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHIFT = 2'b01,
    ST_DONE  = 2'b10
  } frameState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic shiftEn;
    logic commit;
  } dpStrobe_t;

endpackage

// File: rtl/serdac_insync.sv
module serdac_insync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= RST_VAL;
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/serdac_ctrl.sv
module serdac_ctrl
  import serdac_pkg::*;
#(
  parameter int FRAME_W = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      selLow,
  input  logic      sclkLevel,
  output dpStrobe_t strb
);

  localparam int               CNT_W    = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  frameState_t      state, nextState;
  logic [CNT_W-1:0] bitCnt, nextCnt;
  logic             sclkPrev;
  logic             sclkFell;

  assign sclkFell = sclkPrev & ~sclkLevel;

  always_comb begin
    strb      = '0;
    nextState = state;
    nextCnt   = bitCnt;
    case (state)
      ST_IDLE: begin
        if (selLow) begin
          nextState = ST_SHIFT;
          nextCnt   = '0;
        end
      end
      ST_SHIFT: begin
        if (!selLow) begin
          nextState = ST_IDLE;
        end else if (sclkFell) begin
          strb.shiftEn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            strb.commit = 1'b1;
            nextState   = ST_DONE;
          end else begin
            nextCnt = bitCnt + 1'b1;
          end
        end
      end
      ST_DONE: begin
        if (!selLow) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      sclkPrev <= 1'b0;
    end else begin
      state    <= nextState;
      bitCnt   <= nextCnt;
      sclkPrev <= sclkLevel;
    end
  end

endmodule

// File: rtl/serdac_dpath.sv
module serdac_dpath
  import serdac_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 resetToMid,
  input  dpStrobe_t            strb,
  input  logic                 dinBit,
  output logic [CODE_W-1:0]    dacCode,
  output logic [MODE_W-1:0]    pdMode,
  output logic [NUM_MODES-2:0] loadSel
);

  localparam int                PAY_W     = CODE_W + MODE_W;
  localparam logic [CODE_W-1:0] CODE_MID  = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_ZERO = '0;

  // Only the payload bits are kept; leading don't-care bits shift out
  logic [PAY_W-2:0] shiftQ;
  logic [PAY_W-1:0] frameNext;

  assign frameNext = {shiftQ, dinBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '0;
      dacCode <= resetToMid ? CODE_MID : CODE_ZERO;
      pdMode  <= MODE_NORMAL;
    end else begin
      if (strb.shiftEn) shiftQ <= frameNext[PAY_W-2:0];
      if (strb.commit) begin
        dacCode <= frameNext[CODE_W-1:0];
        pdMode  <= frameNext[CODE_W +: MODE_W];
      end
    end
  end

  for (genvar m = 1; m < NUM_MODES; m++) begin : g_load
    assign loadSel[m-1] = (pdMode == MODE_W'(m));
  end

endmodule

// File: rtl/serdac_frontend.sv
module serdac_frontend
  import serdac_pkg::*;
#(
  parameter int FRAME_W     = 24,
  parameter int CODE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 resetToMid,
  input  logic                 serClk,
  input  logic                 serData,
  input  logic                 frameSelN,
  output logic [CODE_W-1:0]    dacCode,
  output logic [MODE_W-1:0]    pdMode,
  output logic [NUM_MODES-2:0] loadSel
);

  // Synchronized bundle order: {frameSelN, serData, serClk}
  localparam int         IN_W       = 3;
  localparam logic [2:0] IN_RST_VAL = 3'b100;

  logic [IN_W-1:0] pinSync;
  logic            selLow;
  dpStrobe_t       ctrlStrb;

  serdac_insync #(
    .WIDTH  (IN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(IN_RST_VAL)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({frameSelN, serData, serClk}),
    .syncOut(pinSync)
  );

  assign selLow = ~pinSync[2];

  serdac_ctrl #(
    .FRAME_W(FRAME_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .selLow   (selLow),
    .sclkLevel(pinSync[0]),
    .strb     (ctrlStrb)
  );

  serdac_dpath #(
    .CODE_W(CODE_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .resetToMid(resetToMid),
    .strb      (ctrlStrb),
    .dinBit    (pinSync[1]),
    .dacCode   (dacCode),
    .pdMode    (pdMode),
    .loadSel   (loadSel)
  );

endmodule

// File: rtl/serdac_chk.sv
module serdac_chk
  import serdac_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 selLow,
  input dpStrobe_t            strb,
  input logic [CODE_W-1:0]    dacCode,
  input logic [MODE_W-1:0]    pdMode,
  input logic [NUM_MODES-2:0] loadSel
);

  logic rearmed;

  always_ff @(posedge clk) begin
    if (!rstN)            rearmed <= 1'b1;
    else if (strb.commit) rearmed <= 1'b0;
    else if (!selLow)     rearmed <= 1'b1;
  end

  // R3
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacCode) |-> $past(strb.commit));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pdMode) |-> $past(strb.commit));

  // R7
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadSel));

  // R4
  commit_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> selLow);

  // R5
  commit_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> rearmed);

endmodule

bind serdac_frontend serdac_chk #(.CODE_W(CODE_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .selLow (selLow),
  .strb   (ctrlStrb),
  .dacCode(dacCode),
  .pdMode (pdMode),
  .loadSel(loadSel)
);

// File: tb/tb_serdac_frontend.sv
`timescale 1ns/1ps
module tb_serdac_frontend;

  localparam int HALF = 4;  // system clocks per serial clock half period

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetToMid = 1'b1;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        frameSelN = 1'b1;
  logic [15:0] dacCode;
  logic [1:0]  pdMode;
  logic [2:0]  loadSel;

  int          checks = 0;
  int          errors = 0;
  logic [15:0] expCode;
  logic [1:0]  expMode;

  serdac_frontend dut (
    .clk       (clk),
    .rstN      (rstN),
    .resetToMid(resetToMid),
    .serClk    (serClk),
    .serData   (serData),
    .frameSelN (frameSelN),
    .dacCode   (dacCode),
    .pdMode    (pdMode),
    .loadSel   (loadSel)
  );

  always #2.5 clk = ~clk;

  function automatic logic [2:0] expLoad(logic [1:0] m);
    case (m)
      2'b01:   return 3'b001;
      2'b10:   return 3'b010;
      2'b11:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkOuts(string tag);
    checks++;
    if (dacCode !== expCode || pdMode !== expMode || loadSel !== expLoad(expMode)) begin
      errors++;
      $display("FAIL %s: code=%h mode=%b load=%b expected code=%h mode=%b load=%b",
               tag, dacCode, pdMode, loadSel, expCode, expMode, expLoad(expMode));
    end
  endtask

  task automatic applyReset(logic mid);
    resetToMid = mid;
    rstN = 1'b0;
    waitClk(3);
    rstN = 1'b1;
    waitClk(1);
    expCode = mid ? 16'h8000 : 16'h0000;
    expMode = 2'b00;
  endtask

  task automatic startFrame();
    frameSelN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic clockBit(logic b);
    serData = b;
    serClk  = 1'b1;
    waitClk(HALF);
    serClk  = 1'b0;
    waitClk(HALF);
  endtask

  task automatic endFrame();
    frameSelN = 1'b1;
    waitClk(2 * HALF);
  endtask

  task automatic sendFrame(logic [23:0] f, int nbits, int extra);
    startFrame();
    for (int i = 0; i < nbits; i++) clockBit(f[23 - i]);
    for (int i = 0; i < extra; i++) clockBit(~f[i % 24]);
    endFrame();
    if (nbits == 24) begin
      expCode = f[15:0];
      expMode = f[17:16];
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_0dac));
    waitClk(1);

    // R1: reset values for both strap settings
    applyReset(1'b1);
    checkOuts("R1 reset midscale");
    waitClk(20);
    checkOuts("R1 midscale holds without a frame");
    applyReset(1'b0);
    checkOuts("R1 reset zero");

    // R2: upper don't-care bits set, normal mode
    sendFrame(24'hFC_1234, 24, 0);
    checkOuts("R2 frame with upper bits set");
    sendFrame(24'h00_ABCD, 24, 0);
    checkOuts("R2 frame with upper bits clear");

    // R3: nothing before the 24th edge, update after it
    startFrame();
    for (int i = 0; i < 23; i++) clockBit(((24'h01_5A5A) >> (23 - i)) & 1'b1);
    checkOuts("R3 before 24th edge");
    clockBit(1'b0);
    expCode = 16'h5A5A;
    expMode = 2'b01;
    checkOuts("R3 after 24th edge");
    endFrame();

    // R4: frame cut one bit short
    sendFrame(24'h00_1111, 23, 0);
    checkOuts("R4 truncated by 1");
    sendFrame(24'h03_2222, 5, 0);
    checkOuts("R4 truncated by 19");

    // R5: extra clocks after the 24th edge
    sendFrame(24'h00_3C3C, 24, 7);
    checkOuts("R5 extra clocks ignored");
    sendFrame(24'h02_7777, 24, 0);
    checkOuts("R5 next frame accepted");

    // R6: clocks while frame select is high
    frameSelN = 1'b1;
    for (int i = 0; i < 30; i++) clockBit(i[0]);
    checkOuts("R6 clocks with select high");

    // R7: every mode and its load select
    for (int m = 0; m < 4; m++) begin
      sendFrame({6'h00, 2'(m), 16'h1000 + 16'(m)}, 24, 0);
      checkOuts("R7 mode decode");
    end

    // R8: power-down write updates code, normal write exits power-down
    sendFrame(24'h03_FFFF, 24, 0);
    checkOuts("R8 code updates in power-down");
    sendFrame(24'h00_0001, 24, 0);
    checkOuts("R8 normal write leaves power-down");

    // R2 R4 R5: seeded random mix
    for (int k = 0; k < 250; k++) begin
      logic [23:0] f;
      int          r;
      int          nb;
      int          ex;
      f  = 24'($urandom);
      r  = $urandom_range(0, 9);
      nb = (r == 0) ? $urandom_range(1, 23) : 24;
      ex = (r == 1) ? $urandom_range(1, 6) : 0;
      sendFrame(f, nb, ex);
      checkOuts("R2 random frame");
    end

    // R1: reset mid-run returns to strap value
    applyReset(1'b1);
    checkOuts("R1 reset after traffic");

    finishRun();
  end

endmodule